// File: doc/BRIEF.md
# Dual-Protocol Host Bus Front End for a Four-Channel Serial Controller

This block sits between an 8-bit parallel host bus and four serial-channel register files. One static input, `mode_sel`, picks how the same set of pins is read. With `mode_sel` high the bus has separate read and write strobes, and each channel has its own active-low select. With `mode_sel` low the bus has one select (`cs_n[0]`), a single read/write line (carried on `wr_n`), and two extra address bits `addr[4:3]` that name the channel.

For every host access the block raises exactly one single-clock read or write pulse toward the addressed channel, derived from a synchronized strobe edge. It also gives the channel the register offset, a divisor-bank flag and the write byte. Read data from the channels is muxed onto the host data bus together with an output-enable. The channel interrupts are presented either as four separately enabled tri-state lines or as one merged open-drain request. The block also converts the reset pin to an internal active-high reset whose polarity follows the mode.

Top module: `hostbus_chan_if`

## Requirements
- R1: With `mode_sel`=1, a `cs_n` pattern with exactly one bit low selects the channel of that bit index (bit 0 = channel 0). Only that channel receives access pulses.
- R2: With `mode_sel`=1, if all `cs_n` bits are high or two or more are low, no channel is accessed and `dout_oe` stays 0.
- R3: With `mode_sel`=0, a channel is selected only while `cs_n[0]` is 0, and then `addr[4:3]`=0,1,2,3 selects channel 0,1,2,3. `cs_n[3:1]` have no effect.
- R4: With `mode_sel`=0, a falling edge on `wr_n` gives a write pulse and a rising edge gives a read pulse. `rd_n` is ignored.
- R5: With `mode_sel`=1, a falling edge of `rd_n` gives a read pulse and a falling edge of `wr_n` gives a write pulse. Each pulse lasts one clock and is visible after the third rising clock edge following the pin edge. `acc_addr`=`addr[2:0]` and, on writes, `acc_data`=`din` are valid with the pulse.
- R6: `acc_div` (with the pulse) and `rd_div` (live) are 1 exactly when the selected channel's `chan_dlab` bit is 1 and `addr[2:1]`=00.
- R7: `dout` carries byte `chan_rdata[8*c+7:8*c]` of the selected channel c. `dout_oe` is 1 when a channel is selected and either `rd_n`=0 (mode 1) or `wr_n`=1 (mode 0).
- R8: With `mode_sel`=1, `int_out[i]`=`chan_irq[i]`, `int_oe[i]`=`intsel` OR `chan_intgate[i]`, and `irq_pull`=0.
- R9: With `mode_sel`=0, `irq_pull` (1 = pull the shared request line low) equals the OR of `chan_irq`, `int_oe` is 0, and `intsel` has no effect.
- R10: `chan_rst` equals `rst_pin` when `mode_sel`=1 and NOT `rst_pin` when `mode_sel`=0. While `chan_rst` is 1, no access pulses appear.
- R11: In any clock, at most one bit across `reg_rd` and `reg_wr` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| mode_sel | input | 1 | 1 = separate strobes, 0 = combined read/write line |
| rst_pin | input | 1 | Reset pin, polarity set by mode |
| cs_n | input | 4 | Per-channel selects (mode 1); bit 0 is the common select (mode 0) |
| addr | input | 5 | [2:0] register offset; [4:3] channel number in mode 0 |
| rd_n | input | 1 | Read strobe, mode 1 only |
| wr_n | input | 1 | Write strobe (mode 1) or read/write line (mode 0) |
| din | input | 8 | Host write data from the pad |
| dout | output | 8 | Host read data toward the pad |
| dout_oe | output | 1 | Drive enable for `dout` |
| intsel | input | 1 | Forces all interrupt lines driven in mode 1 |
| chan_rdata | input | 32 | Read byte from each channel, channel c at bits 8c+7:8c |
| chan_dlab | input | 4 | Divisor-bank enable of each channel |
| chan_irq | input | 4 | Interrupt request of each channel |
| chan_intgate | input | 4 | Per-channel interrupt output enable bit |
| chan_rst | output | 1 | Active-high reset to the channels |
| rd_addr | output | 3 | Live register offset for the read mux |
| rd_div | output | 1 | Live divisor-bank flag for the read mux |
| reg_rd | output | 4 | One-clock read pulse per channel |
| reg_wr | output | 4 | One-clock write pulse per channel |
| acc_addr | output | 3 | Register offset of the latest access |
| acc_div | output | 1 | Divisor-bank flag of the latest access |
| acc_data | output | 8 | Write byte of the latest write |
| int_out | output | 4 | Per-channel interrupt level, mode 1 |
| int_oe | output | 4 | Drive enable of each `int_out` line |
| irq_pull | output | 1 | 1 pulls the shared open-drain request low, mode 0 |

## Verification
The hardest case to reach is the combined-mode read. There the access pulse comes from the rising edge of the read/write line, so the bench must first produce a write on the falling edge. It must keep the select and channel bits steady through both edges, and then see a second and distinct pulse to the same channel. Each table vector holds every pin static around a full low-then-high excursion of the strobe and counts the pulses per channel over that window. This shows both the one-pulse-per-edge rule and the absence of pulses on unselected or collided channels. Further directed cases cover the exact pulse latency, the data bus enable with several selects low, and the reset polarity.

// File: rtl/hb_pkg.sv
package hb_pkg;
    localparam int HB_NCH = 4;
    localparam int HB_CHW = $clog2(HB_NCH);
    localparam int HB_DW  = 8;
    localparam int HB_RAW = 3;

    // One sampled view of the host pins, after channel decode
    typedef struct packed {
        logic              mode;
        logic              ok;
        logic [HB_CHW-1:0] ch;
        logic [HB_RAW-1:0] ra;
        logic [HB_DW-1:0]  data;
        logic              rd_n;
        logic              wr_n;
    } hb_samp_t;

    localparam hb_samp_t HB_SAMP_IDLE = '{
        mode: 1'b1, ok: 1'b0, ch: '0, ra: '0, data: '0, rd_n: 1'b1, wr_n: 1'b1
    };
endpackage

// File: rtl/hb_chan_decode.sv
module hb_chan_decode #(
    parameter int NCH = hb_pkg::HB_NCH,
    localparam int CHW = $clog2(NCH)
) (
    input  logic           mode_sel,
    input  logic [NCH-1:0] cs_n,
    input  logic [CHW-1:0] chan_bits,
    output logic           sel_ok,
    output logic [CHW-1:0] sel_ch
);
    logic [CHW-1:0] strobe_ch;
    int unsigned    low_cnt;

    // Separate-select style: exactly one low select wins
    always_comb begin
        low_cnt   = 0;
        strobe_ch = '0;
        for (int i = 0; i < NCH; i++) begin
            if (!cs_n[i]) begin
                low_cnt   = low_cnt + 1;
                strobe_ch = CHW'(i);
            end
        end
    end

    always_comb begin
        if (mode_sel) begin
            sel_ok = (low_cnt == 1);
            sel_ch = strobe_ch;
        end else begin
            sel_ok = !cs_n[0];
            sel_ch = chan_bits;
        end
    end
endmodule

// File: rtl/hb_strobe_sync.sv
module hb_strobe_sync #(
    parameter int NCH = hb_pkg::HB_NCH,
    parameter int DW  = hb_pkg::HB_DW,
    parameter int RAW = hb_pkg::HB_RAW
) (
    input  logic             clk,
    input  logic             rst,
    input  hb_pkg::hb_samp_t samp_in,
    input  logic [NCH-1:0]   dlab,
    output logic [NCH-1:0]   rd_pls,
    output logic [NCH-1:0]   wr_pls,
    output logic [RAW-1:0]   acc_addr,
    output logic             acc_div,
    output logic [DW-1:0]    acc_data
);
    import hb_pkg::*;

    typedef struct packed {
        hb_samp_t       s1;
        hb_samp_t       s2;
        logic           prv_rd_n;
        logic           prv_wr_n;
        logic [NCH-1:0] rd;
        logic [NCH-1:0] wr;
        logic [RAW-1:0] addr;
        logic           div;
        logic [DW-1:0]  data;
    } sync_st_t;

    sync_st_t st_d, st_q;
    logic rd_fall, wr_fall, wr_rise, rd_ev, wr_ev, div_hit;

    always_comb begin
        st_d          = st_q;
        st_d.s1       = samp_in;
        st_d.s2       = st_q.s1;
        st_d.prv_rd_n = st_q.s2.rd_n;
        st_d.prv_wr_n = st_q.s2.wr_n;

        rd_fall = st_q.prv_rd_n & ~st_q.s2.rd_n;
        wr_fall = st_q.prv_wr_n & ~st_q.s2.wr_n;
        wr_rise = ~st_q.prv_wr_n & st_q.s2.wr_n;

        if (st_q.s2.mode) begin
            rd_ev = rd_fall & ~wr_fall;
            wr_ev = wr_fall & ~rd_fall;
        end else begin
            rd_ev = wr_rise;
            wr_ev = wr_fall;
        end
        rd_ev = rd_ev & st_q.s2.ok;
        wr_ev = wr_ev & st_q.s2.ok;

        div_hit = dlab[st_q.s2.ch] && (st_q.s2.ra[RAW-1:1] == '0);

        for (int i = 0; i < NCH; i++) begin
            st_d.rd[i] = rd_ev && (st_q.s2.ch == $bits(st_q.s2.ch)'(i));
            st_d.wr[i] = wr_ev && (st_q.s2.ch == $bits(st_q.s2.ch)'(i));
        end

        if (rd_ev || wr_ev) begin
            st_d.addr = st_q.s2.ra;
            st_d.div  = div_hit;
        end
        if (wr_ev) begin
            st_d.data = st_q.s2.data;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q.s1       <= HB_SAMP_IDLE;
            st_q.s2       <= HB_SAMP_IDLE;
            st_q.prv_rd_n <= 1'b1;
            st_q.prv_wr_n <= 1'b1;
            st_q.rd       <= '0;
            st_q.wr       <= '0;
            st_q.addr     <= '0;
            st_q.div      <= 1'b0;
            st_q.data     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_pls   = st_q.rd;
    assign wr_pls   = st_q.wr;
    assign acc_addr = st_q.addr;
    assign acc_div  = st_q.div;
    assign acc_data = st_q.data;
endmodule

// File: rtl/hb_irq_merge.sv
module hb_irq_merge #(
    parameter int NCH = hb_pkg::HB_NCH
) (
    input  logic           mode_sel,
    input  logic           intsel,
    input  logic [NCH-1:0] chan_irq,
    input  logic [NCH-1:0] chan_intgate,
    output logic [NCH-1:0] int_out,
    output logic [NCH-1:0] int_oe,
    output logic           irq_pull
);
    for (genvar g = 0; g < NCH; g++) begin : g_line
        assign int_out[g] = chan_irq[g];
        assign int_oe[g]  = mode_sel & (intsel | chan_intgate[g]);
    end

    assign irq_pull = !mode_sel && (|chan_irq);
endmodule

// File: rtl/hostbus_chan_if.sv
module hostbus_chan_if #(
    parameter int NCH = hb_pkg::HB_NCH,
    parameter int DW  = hb_pkg::HB_DW,
    parameter int RAW = hb_pkg::HB_RAW,
    localparam int CHW = $clog2(NCH),
    localparam int AW  = RAW + CHW
) (
    input  logic              clk,
    input  logic              mode_sel,
    input  logic              rst_pin,
    input  logic [NCH-1:0]    cs_n,
    input  logic [AW-1:0]     addr,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DW-1:0]     din,
    output logic [DW-1:0]     dout,
    output logic              dout_oe,
    input  logic              intsel,
    input  logic [NCH*DW-1:0] chan_rdata,
    input  logic [NCH-1:0]    chan_dlab,
    input  logic [NCH-1:0]    chan_irq,
    input  logic [NCH-1:0]    chan_intgate,
    output logic              chan_rst,
    output logic [RAW-1:0]    rd_addr,
    output logic              rd_div,
    output logic [NCH-1:0]    reg_rd,
    output logic [NCH-1:0]    reg_wr,
    output logic [RAW-1:0]    acc_addr,
    output logic              acc_div,
    output logic [DW-1:0]     acc_data,
    output logic [NCH-1:0]    int_out,
    output logic [NCH-1:0]    int_oe,
    output logic              irq_pull
);
    import hb_pkg::*;

    logic           rst_int;
    logic           sel_ok;
    logic [CHW-1:0] sel_ch;
    hb_samp_t       samp;

    // Reset pin polarity follows the bus style
    assign rst_int  = mode_sel ? rst_pin : ~rst_pin;
    assign chan_rst = rst_int;

    hb_chan_decode #(.NCH(NCH)) u_dec (
        .mode_sel  (mode_sel),
        .cs_n      (cs_n),
        .chan_bits (addr[AW-1:RAW]),
        .sel_ok    (sel_ok),
        .sel_ch    (sel_ch)
    );

    always_comb begin
        samp      = HB_SAMP_IDLE;
        samp.mode = mode_sel;
        samp.ok   = sel_ok;
        samp.ch   = sel_ch;
        samp.ra   = addr[RAW-1:0];
        samp.data = din;
        samp.rd_n = rd_n;
        samp.wr_n = wr_n;
    end

    hb_strobe_sync #(.NCH(NCH), .DW(DW), .RAW(RAW)) u_sync (
        .clk      (clk),
        .rst      (rst_int),
        .samp_in  (samp),
        .dlab     (chan_dlab),
        .rd_pls   (reg_rd),
        .wr_pls   (reg_wr),
        .acc_addr (acc_addr),
        .acc_div  (acc_div),
        .acc_data (acc_data)
    );

    // Live read path toward the channel register mux and the pad
    assign rd_addr = addr[RAW-1:0];
    assign rd_div  = sel_ok && chan_dlab[sel_ch] && (addr[RAW-1:1] == '0);
    assign dout    = chan_rdata[sel_ch*DW +: DW];
    assign dout_oe = sel_ok && (mode_sel ? !rd_n : wr_n);

    hb_irq_merge #(.NCH(NCH)) u_irq (
        .mode_sel     (mode_sel),
        .intsel       (intsel),
        .chan_irq     (chan_irq),
        .chan_intgate (chan_intgate),
        .int_out      (int_out),
        .int_oe       (int_oe),
        .irq_pull     (irq_pull)
    );
endmodule

// File: rtl/hostbus_chan_if_chk.sv
module hostbus_chan_if_chk #(
    parameter int NCH = hb_pkg::HB_NCH
) (
    input logic           clk,
    input logic           mode_sel,
    input logic [NCH-1:0] cs_n,
    input logic           intsel,
    input logic [NCH-1:0] chan_irq,
    input logic [NCH-1:0] chan_intgate,
    input logic           chan_rst,
    input logic [NCH-1:0] reg_rd,
    input logic [NCH-1:0] reg_wr,
    input logic           dout_oe,
    input logic [NCH-1:0] int_oe,
    input logic           irq_pull
);
    p_quiet_in_rst_r10: assert property (@(posedge clk)
        chan_rst |-> (reg_rd == '0 && reg_wr == '0));

    p_single_pulse_r11: assert property (@(posedge clk) disable iff (chan_rst)
        $onehot0({reg_rd, reg_wr}));

    p_one_cycle_r5: assert property (@(posedge clk) disable iff (chan_rst)
        (|{reg_rd, reg_wr}) |=> !(|{reg_rd, reg_wr}));

    p_collide_undriven_r2: assert property (@(posedge clk) disable iff (chan_rst)
        (mode_sel && $countones(~cs_n) > 1) |-> !dout_oe);

    p_line_enable_r8: assert property (@(posedge clk) disable iff (chan_rst)
        mode_sel |-> (int_oe == (chan_intgate | {NCH{intsel}}) && !irq_pull));

    p_merged_req_r9: assert property (@(posedge clk) disable iff (chan_rst)
        !mode_sel |-> (irq_pull == (|chan_irq) && int_oe == '0));
endmodule

bind hostbus_chan_if hostbus_chan_if_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/hostbus_chan_if_test.sv
module hostbus_chan_if_test;
    logic        clk = 1'b0;
    logic        mode_sel = 1'b1;
    logic        rst_pin = 1'b1;
    logic [3:0]  cs_n = 4'hF;
    logic [4:0]  addr = '0;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [7:0]  din = '0;
    logic        intsel = 1'b0;
    logic [31:0] chan_rdata = 32'h44332211;
    logic [3:0]  chan_dlab = '0;
    logic [3:0]  chan_irq = '0;
    logic [3:0]  chan_intgate = '0;
    logic [7:0]  dout;
    logic        dout_oe, chan_rst, rd_div, acc_div, irq_pull;
    logic [2:0]  rd_addr, acc_addr;
    logic [3:0]  reg_rd, reg_wr, int_out, int_oe;
    logic [7:0]  acc_data;

    int nvec  = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    hostbus_chan_if uut (
        .clk(clk), .mode_sel(mode_sel), .rst_pin(rst_pin), .cs_n(cs_n), .addr(addr),
        .rd_n(rd_n), .wr_n(wr_n), .din(din), .dout(dout), .dout_oe(dout_oe),
        .intsel(intsel), .chan_rdata(chan_rdata), .chan_dlab(chan_dlab),
        .chan_irq(chan_irq), .chan_intgate(chan_intgate), .chan_rst(chan_rst),
        .rd_addr(rd_addr), .rd_div(rd_div), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .acc_addr(acc_addr), .acc_div(acc_div), .acc_data(acc_data),
        .int_out(int_out), .int_oe(int_oe), .irq_pull(irq_pull)
    );

    // {mode, cs_n[3:0], addr[4:0], op(1=write, mode 1 only), din[7:0],
    //  dlab[3:0], exp_rd[3:0], exp_wr[3:0], exp_div}
    localparam int NV = 16;
    localparam logic [31:0] VEC [NV] = '{
        {1'b1, 4'b1110, 5'b00011, 1'b1, 8'hA5, 4'b0000, 4'b0000, 4'b0001, 1'b0},
        {1'b1, 4'b1101, 5'b00100, 1'b0, 8'h00, 4'b0000, 4'b0010, 4'b0000, 1'b0},
        {1'b1, 4'b1011, 5'b00000, 1'b1, 8'h3C, 4'b0100, 4'b0000, 4'b0100, 1'b1},
        {1'b1, 4'b0111, 5'b00001, 1'b0, 8'h00, 4'b0000, 4'b1000, 4'b0000, 1'b0},
        {1'b1, 4'b0111, 5'b00001, 1'b1, 8'h81, 4'b1000, 4'b0000, 4'b1000, 1'b1},
        {1'b1, 4'b1100, 5'b00010, 1'b1, 8'h77, 4'b0000, 4'b0000, 4'b0000, 1'b0},
        {1'b1, 4'b0000, 5'b00010, 1'b0, 8'h00, 4'b0000, 4'b0000, 4'b0000, 1'b0},
        {1'b1, 4'b1111, 5'b00010, 1'b1, 8'h66, 4'b0000, 4'b0000, 4'b0000, 1'b0},
        {1'b0, 4'b1110, 5'b00101, 1'b0, 8'h11, 4'b0000, 4'b0001, 4'b0001, 1'b0},
        {1'b0, 4'b1110, 5'b01110, 1'b0, 8'h5E, 4'b0000, 4'b0010, 4'b0010, 1'b0},
        {1'b0, 4'b1110, 5'b10000, 1'b0, 8'hC3, 4'b0100, 4'b0100, 4'b0100, 1'b1},
        {1'b0, 4'b1110, 5'b11001, 1'b0, 8'h9F, 4'b1000, 4'b1000, 4'b1000, 1'b1},
        {1'b0, 4'b1111, 5'b11001, 1'b0, 8'h12, 4'b0000, 4'b0000, 4'b0000, 1'b0},
        {1'b0, 4'b0001, 5'b01000, 1'b0, 8'h34, 4'b0000, 4'b0000, 4'b0000, 1'b0},
        {1'b0, 4'b1110, 5'b00010, 1'b0, 8'h56, 4'b0001, 4'b0001, 4'b0001, 1'b0},
        {1'b1, 4'b1110, 5'b00000, 1'b0, 8'h00, 4'b0010, 4'b0001, 4'b0000, 1'b0}
    };

    int       rd_cnt [4];
    int       wr_cnt [4];
    logic [2:0] last_addr;
    logic       last_div;
    logic [7:0] last_data;

    task automatic check(input bit ok, input string tag, input logic [31:0] got,
                         input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic clear_counts();
        for (int i = 0; i < 4; i++) begin
            rd_cnt[i] = 0;
            wr_cnt[i] = 0;
        end
    endtask

    // Wait for the next falling clock edge and tally the registered pulses
    task automatic step();
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            if (reg_rd[i]) rd_cnt[i]++;
            if (reg_wr[i]) wr_cnt[i]++;
        end
        if (|{reg_rd, reg_wr}) begin
            last_addr = acc_addr;
            last_div  = acc_div;
        end
        if (|reg_wr) last_data = acc_data;
    endtask

    task automatic set_mode(input logic m);
        mode_sel = m;
        rst_pin  = ~m;
    endtask

    task automatic run_vec(input logic [31:0] v, input int idx);
        logic       m, op, ediv;
        logic [3:0] erd, ewr, grd, gwr;
        logic [4:0] a;
        string      tag;
        bit         ok;
        m = v[31]; a = v[26:22]; op = v[21];
        erd = v[8:5]; ewr = v[4:1]; ediv = v[0];
        @(negedge clk);
        set_mode(m);
        cs_n = v[30:27]; addr = a; din = v[20:13]; chan_dlab = v[12:9];
        rd_n = 1'b1; wr_n = 1'b1;
        repeat (3) step();
        clear_counts();
        if (m && !op) rd_n = 1'b0; else wr_n = 1'b0;
        repeat (6) step();
        rd_n = 1'b1; wr_n = 1'b1;
        repeat (6) step();
        ok = 1'b1;
        for (int i = 0; i < 4; i++) begin
            grd[i] = (rd_cnt[i] != 0);
            gwr[i] = (wr_cnt[i] != 0);
            if (rd_cnt[i] != int'(erd[i]) || wr_cnt[i] != int'(ewr[i])) ok = 1'b0;
        end
        if (|{erd, ewr}) begin
            if (last_addr != a[2:0] || last_div != ediv) ok = 1'b0;
        end
        if (|ewr && last_data != v[20:13]) ok = 1'b0;
        // R1 R2 for mode 1, R3 R4 for mode 0, R6 divisor flag in both
        tag = $sformatf("%s vector %0d (R6 div)", m ? "R1 R2" : "R3 R4", idx);
        check(ok, tag, {16'h0, grd, gwr, 4'h0, 3'h0, last_div},
              {16'h0, erd, ewr, 4'h0, 3'h0, ediv});
    endtask

    initial begin
        #(200000 * 20);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        bit seen;
        last_addr = '0; last_div = 1'b0; last_data = '0;
        clear_counts();
        repeat (3) @(negedge clk);
        // R10 reset active high in mode 1
        check(chan_rst == 1'b1, "R10 reset high in mode 1", 32'(chan_rst), 32'd1);
        rst_pin = 1'b0;
        repeat (2) @(negedge clk);
        check(reg_rd == 4'h0 && reg_wr == 4'h0 && !dout_oe && !chan_rst,
              "R10 reset state", {reg_rd, reg_wr, 2'b0, dout_oe, chan_rst}, 32'h0);

        for (int v = 0; v < NV; v++) run_vec(VEC[v], v);

        // R5 exact latency: pulse after the third rising edge, one clock wide
        @(negedge clk);
        set_mode(1'b1); cs_n = 4'b1101; addr = 5'b00110; din = 8'hE7;
        repeat (3) step();
        wr_n = 1'b0;
        @(negedge clk);
        seen = (reg_wr != 0);
        @(negedge clk);
        seen = seen || (reg_wr != 0);
        check(!seen, "R5 no pulse before third edge", 32'(reg_wr), 32'h0);
        @(negedge clk);
        check(reg_wr == 4'b0010 && acc_addr == 3'd6 && acc_data == 8'hE7,
              "R5 pulse at third edge", {reg_wr, acc_addr, acc_data}, {4'b0010, 3'd6, 8'hE7});
        @(negedge clk);
        check(reg_wr == 4'b0000, "R5 pulse one clock wide", 32'(reg_wr), 32'h0);
        wr_n = 1'b1;
        repeat (4) @(negedge clk);

        // R7 read data path in mode 1
        chan_rdata = 32'hD4C3B2A1;
        cs_n = 4'b1011; rd_n = 1'b0; #1;
        check(dout_oe && dout == 8'hC3, "R7 mode 1 read drive", {dout_oe, dout}, {1'b1, 8'hC3});
        cs_n = 4'b1001; #1;
        check(!dout_oe, "R2 collided selects undriven", 32'(dout_oe), 32'h0);
        rd_n = 1'b1; cs_n = 4'hF;
        repeat (4) @(negedge clk);

        // R7 and R6 live path in mode 0
        set_mode(1'b0);
        cs_n = 4'b1110; addr = 5'b10001; chan_dlab = 4'b0100; wr_n = 1'b1; #1;
        check(dout_oe && dout == 8'hC3 && rd_div && rd_addr == 3'd1,
              "R7 R6 mode 0 read drive", {dout_oe, rd_div, rd_addr, dout},
              {1'b1, 1'b1, 3'd1, 8'hC3});
        addr = 5'b10010; #1;
        check(!rd_div, "R6 offset 2 not divisor", 32'(rd_div), 32'h0);

        // R4 rd_n ignored in mode 0
        repeat (3) step();
        clear_counts();
        rd_n = 1'b0;
        repeat (6) step();
        rd_n = 1'b1;
        repeat (6) step();
        check(rd_cnt[2] == 0 && wr_cnt[2] == 0 && dout_oe, "R4 rd_n ignored",
              {rd_cnt[2][15:0], wr_cnt[2][15:0]}, 32'h0);
        cs_n = 4'hF;

        // R9 merged request, intsel ignored
        intsel = 1'b1; chan_intgate = 4'b1111; chan_irq = 4'b0010; #1;
        check(irq_pull && int_oe == 4'h0, "R9 merged request", {irq_pull, int_oe}, {1'b1, 4'h0});
        chan_irq = 4'b0000; #1;
        check(!irq_pull, "R9 no request", 32'(irq_pull), 32'h0);

        // R10 reset active low in mode 0, no pulses while held
        rst_pin = 1'b0; #1;
        check(chan_rst, "R10 reset low in mode 0", 32'(chan_rst), 32'd1);
        cs_n = 4'b1110; addr = 5'b00000;
        repeat (2) step();
        clear_counts();
        wr_n = 1'b0;
        repeat (6) step();
        wr_n = 1'b1;
        repeat (6) step();
        check(wr_cnt[0] == 0 && rd_cnt[0] == 0, "R10 no pulse in reset",
              {rd_cnt[0][15:0], wr_cnt[0][15:0]}, 32'h0);
        rst_pin = 1'b1; cs_n = 4'hF; #1;
        check(!chan_rst, "R10 release in mode 0", 32'(chan_rst), 32'h0);

        // R8 per-line interrupt enables in mode 1
        @(negedge clk);
        set_mode(1'b1);
        intsel = 1'b0; chan_intgate = 4'b0101; chan_irq = 4'b1111; #1;
        check(int_oe == 4'b0101 && int_out == 4'b1111 && !irq_pull, "R8 gated lines",
              {irq_pull, int_oe, int_out}, {1'b0, 4'b0101, 4'b1111});
        intsel = 1'b1; chan_irq = 4'b1010; #1;
        check(int_oe == 4'b1111 && int_out == 4'b1010, "R8 intsel forces drive",
              {int_oe, int_out}, {4'b1111, 4'b1010});
        repeat (3) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule